// File: doc/BRIEF.md
# Packed Signed Halfword Multiplier with Pairwise Dot Product

This block multiplies two 64-bit operands lane by lane. Each operand holds four signed 16-bit lanes, and the block forms all four full-width signed products at once. A two-bit operation code picks the result. The result can be the upper half of every product, the lower half of every product, or two 32-bit sums, each built from a neighbouring pair of products.

The unit is pipelined. It accepts a new operation on every cycle in which `in_valid` is high. The matching result appears exactly three cycles later, marked by `out_valid`. The operation code travels down the pipeline with its data, so operations of different kinds can follow one another on consecutive cycles. The result port keeps its last value while no result is being delivered.

Top module: `pmul_unit`

## Requirements
- R1: Each operand is split into four signed 16-bit lanes, with lane i in bits [16i+15:16i]. Each lane product is the full 32-bit two's-complement product of the two lane i values.
- R2: With operation code 2'b00 (high halves), result lane i holds bits [31:16] of lane product i.
- R3: With operation code 2'b01 (low halves), result lane i holds bits [15:0] of lane product i.
- R4: With operation code 2'b10 (pairwise dot product), result bits [63:32] hold product3 + product2 and bits [31:0] hold product1 + product0, each sum taken modulo 2^32.
- R5: In pairwise mode, when every input lane is 16'h8000, each 32-bit half of the result is 32'h8000_0000 (the wrap of 2^31).
- R6: An operation accepted with `in_valid` high at a clock edge produces `out_valid` high after the third following edge. Operations may be accepted on back-to-back cycles, and each yields its own result in order.
- R7: Operation code 2'b11 is reserved. It still produces `out_valid` with the normal latency, with a result of all zeros.
- R8: While `rst_n` is low, `out_valid` and `out_result` are zero. Operations that were in flight when reset was asserted never produce an `out_valid`.
- R9: While `out_valid` is low, `out_result` keeps the value it last held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present on the inputs this cycle |
| in_op | input | 2 | Operation code: 00 high, 01 low, 10 pairwise dot product, 11 reserved |
| in_a | input | 64 | First operand, four signed 16-bit lanes |
| in_b | input | 64 | Second operand, four signed 16-bit lanes |
| out_valid | output | 1 | Result present on `out_result` this cycle |
| out_result | output | 64 | Packed result |

## Verification
The hardest situation to reach from the ports is a pipeline that is full of operations of mixed kinds, so that each stage holds a different operation code. In that state, a code that was not carried correctly would format some other operation's products. The stimulus table is therefore applied back to back, with no idle cycles and with codes interleaved, while results are checked three cycles behind the inputs. A second hard case is asserting reset while the pipeline is still full. A directed sequence loads three operations, asserts reset after the first result appears, and confirms that none of the others ever surfaces.

// File: rtl/pmul_pkg.sv
package pmul_pkg;

  typedef enum logic [1:0] {
    PM_HI   = 2'b00,
    PM_LO   = 2'b01,
    PM_MADD = 2'b10,
    PM_RSVD = 2'b11
  } pm_op_e;

endpackage

// File: rtl/pmul_lane_mul.sv
// One lane: registered full-width signed product of two LW-bit values.
module pmul_lane_mul #(
  parameter int LW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [LW-1:0]   a,
  input  logic [LW-1:0]   b,
  output logic [2*LW-1:0] prod
);

  localparam int PW = 2 * LW;

  logic [PW-1:0] a_ext;
  logic [PW-1:0] b_ext;
  logic [PW-1:0] prod_d;

  // The low PW bits of the product of sign-extended values equal the signed product.
  always_comb begin
    a_ext  = {{LW{a[LW-1]}}, a};
    b_ext  = {{LW{b[LW-1]}}, b};
    prod_d = a_ext * b_ext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod <= '0;
    end else if (en) begin
      prod <= prod_d;
    end
  end

endmodule

// File: rtl/pmul_pack.sv
// Combinational result formatting from the lane products.
module pmul_pack #(
  parameter int LANES = 4,
  parameter int LW    = 16
) (
  input  logic [1:0]              op,
  input  logic [LANES*2*LW-1:0]   prods,
  output logic [LANES*LW-1:0]     result
);
  import pmul_pkg::*;

  localparam int PW    = 2 * LW;
  localparam int DW    = LANES * LW;
  localparam int PAIRS = LANES / 2;

  logic [DW-1:0] hi_vec;
  logic [DW-1:0] lo_vec;
  logic [DW-1:0] madd_vec;

  for (genvar i = 0; i < LANES; i++) begin : g_half
    assign hi_vec[i*LW +: LW] = prods[i*PW + LW +: LW];
    assign lo_vec[i*LW +: LW] = prods[i*PW +: LW];
  end

  for (genvar k = 0; k < PAIRS; k++) begin : g_pair
    assign madd_vec[k*PW +: PW] = prods[(2*k)*PW +: PW] + prods[(2*k+1)*PW +: PW];
  end

  always_comb begin
    unique case (pm_op_e'(op))
      PM_HI:   result = hi_vec;
      PM_LO:   result = lo_vec;
      PM_MADD: result = madd_vec;
      default: result = '0;
    endcase
  end

endmodule

// File: rtl/pmul_unit.sv
// Three-stage packed multiplier: operand register, product register, result register.
module pmul_unit #(
  parameter int LANES = 4,
  parameter int LW    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [1:0]          in_op,
  input  logic [LANES*LW-1:0] in_a,
  input  logic [LANES*LW-1:0] in_b,
  output logic                out_valid,
  output logic [LANES*LW-1:0] out_result
);

  localparam int DW = LANES * LW;
  localparam int PW = 2 * LW;

  // Stage 1: operands
  logic          s1_valid, s1_valid_d;
  logic [1:0]    s1_op,    s1_op_d;
  logic [DW-1:0] s1_a,     s1_a_d;
  logic [DW-1:0] s1_b,     s1_b_d;

  // Stage 2: products
  logic                s2_valid, s2_valid_d;
  logic [1:0]          s2_op,    s2_op_d;
  logic [LANES*PW-1:0] s2_prods;

  // Stage 3: result
  logic          s3_valid_d;
  logic [DW-1:0] s3_result_d;
  logic [DW-1:0] fmt_result;

  // Stage 1 next state
  always_comb begin
    s1_valid_d = in_valid;
    s1_op_d    = s1_op;
    s1_a_d     = s1_a;
    s1_b_d     = s1_b;
    if (in_valid) begin
      s1_op_d = in_op;
      s1_a_d  = in_a;
      s1_b_d  = in_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_op    <= '0;
      s1_a     <= '0;
      s1_b     <= '0;
    end else begin
      s1_valid <= s1_valid_d;
      s1_op    <= s1_op_d;
      s1_a     <= s1_a_d;
      s1_b     <= s1_b_d;
    end
  end

  // Stage 2: lane multipliers, enabled only for a live operation
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    pmul_lane_mul #(.LW(LW)) u_mul (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (s1_valid),
      .a    (s1_a[i*LW +: LW]),
      .b    (s1_b[i*LW +: LW]),
      .prod (s2_prods[i*PW +: PW])
    );
  end

  always_comb begin
    s2_valid_d = s1_valid;
    s2_op_d    = s1_valid ? s1_op : s2_op;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_valid <= 1'b0;
      s2_op    <= '0;
    end else begin
      s2_valid <= s2_valid_d;
      s2_op    <= s2_op_d;
    end
  end

  // Stage 3: format and hold
  pmul_pack #(.LANES(LANES), .LW(LW)) u_pack (
    .op    (s2_op),
    .prods (s2_prods),
    .result(fmt_result)
  );

  always_comb begin
    s3_valid_d  = s2_valid;
    s3_result_d = s2_valid ? fmt_result : out_result;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
    end else begin
      out_valid  <= s3_valid_d;
      out_result <= s3_result_d;
    end
  end

endmodule

// File: rtl/pmul_unit_chk.sv
// Checker: keeps its own three-deep copy of accepted operations and compares.
module pmul_unit_chk #(
  parameter int LANES = 4,
  parameter int LW    = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [1:0]          in_op,
  input logic [LANES*LW-1:0] in_a,
  input logic [LANES*LW-1:0] in_b,
  input logic                out_valid,
  input logic [LANES*LW-1:0] out_result
);
  localparam int DW = LANES * LW;
  localparam int PW = 2 * LW;

  logic          v1, v2, v3;
  logic [1:0]    o1, o2, o3;
  logic [DW-1:0] a1, a2, a3;
  logic [DW-1:0] b1, b2, b3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0; v2 <= 1'b0; v3 <= 1'b0;
      o1 <= '0;   o2 <= '0;   o3 <= '0;
      a1 <= '0;   a2 <= '0;   a3 <= '0;
      b1 <= '0;   b2 <= '0;   b3 <= '0;
    end else begin
      v1 <= in_valid; v2 <= v1; v3 <= v2;
      o1 <= in_op;    o2 <= o1; o3 <= o2;
      a1 <= in_a;     a2 <= a1; a3 <= a2;
      b1 <= in_b;     b2 <= b1; b3 <= b2;
    end
  end

  logic [PW-1:0] p [LANES];
  logic [DW-1:0] exp_hi, exp_lo, exp_madd;

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      p[i] = PW'($signed(a3[i*LW +: LW]) * $signed(b3[i*LW +: LW]));
      exp_hi[i*LW +: LW] = p[i][PW-1:LW];
      exp_lo[i*LW +: LW] = p[i][LW-1:0];
    end
    for (int k = 0; k < LANES/2; k++) begin
      exp_madd[k*PW +: PW] = p[2*k] + p[2*k+1];
    end
  end

  // R6
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == v3);

  // R2
  mul_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && o3 == 2'b00) |-> out_result == exp_hi);

  // R3
  mul_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && o3 == 2'b01) |-> out_result == exp_lo);

  // R4
  pair_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && o3 == 2'b10) |-> out_result == exp_madd);

  // R7
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && o3 == 2'b11) |-> out_result == '0);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_result));

endmodule

bind pmul_unit pmul_unit_chk #(.LANES(LANES), .LW(LW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_op     (in_op),
  .in_a      (in_a),
  .in_b      (in_b),
  .out_valid (out_valid),
  .out_result(out_result)
);

// File: tb/pmul_unit_tb.sv
`timescale 1ns/1ps
module pmul_unit_tb;

  localparam int NV = 12;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  in_op;
  logic [63:0] in_a;
  logic [63:0] in_b;
  logic        out_valid;
  logic [63:0] out_result;

  int checks;
  int fails;
  bit done;

  pmul_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_result(out_result)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Stimulus table: {op, a, b}
  localparam logic [129:0] VEC [NV] = '{
    {2'b00, 64'h0001_0002_0003_0004, 64'h0005_0006_0007_0008},
    {2'b01, 64'h0001_0002_0003_0004, 64'h0005_0006_0007_0008},
    {2'b00, 64'hFFFF_7FFF_8000_1234, 64'h0001_7FFF_8000_FFFE},
    {2'b01, 64'hFFFF_7FFF_8000_1234, 64'h0001_7FFF_8000_FFFE},
    {2'b10, 64'h0001_0002_0003_0004, 64'h0005_0006_0007_0008},
    {2'b10, 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000},
    {2'b11, 64'h1234_5678_9ABC_DEF0, 64'h1111_2222_3333_4444},
    {2'b10, 64'hFFFF_8001_7FFF_0000, 64'h7FFF_FFFF_8001_ABCD},
    {2'b00, 64'hA5A5_5A5A_C3C3_3C3C, 64'h5A5A_A5A5_3C3C_C3C3},
    {2'b01, 64'hA5A5_5A5A_C3C3_3C3C, 64'h5A5A_A5A5_3C3C_C3C3},
    {2'b10, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_FFFF_FFFF},
    {2'b00, 64'h0000_0000_0000_0000, 64'h1234_5678_9ABC_DEF0}
  };

  // Reference model built from R1..R4, R7
  function automatic logic [63:0] model(input logic [1:0] op, input logic [63:0] a,
                                        input logic [63:0] b);
    logic signed [31:0] pr [4];
    logic [63:0] r;
    for (int i = 0; i < 4; i++) pr[i] = $signed(a[i*16 +: 16]) * $signed(b[i*16 +: 16]);
    r = '0;
    case (op)
      2'b00: for (int i = 0; i < 4; i++) r[i*16 +: 16] = pr[i][31:16];
      2'b01: for (int i = 0; i < 4; i++) r[i*16 +: 16] = pr[i][15:0];
      2'b10: begin
        r[63:32] = pr[3] + pr[2];
        r[31:0]  = pr[1] + pr[0];
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string req_of(input logic [1:0] op, input logic [63:0] a);
    if (op == 2'b00) return "R2";
    if (op == 2'b01) return "R3";
    if (op == 2'b10) return (a == 64'h8000_8000_8000_8000) ? "R5" : "R4";
    return "R7";
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    logic [63:0] last_exp;
    logic [1:0]  op;
    logic [63:0] a, b;
    checks = 0; fails = 0; done = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_op = '0; in_a = '0; in_b = '0;
    repeat (3) @(negedge clk);
    // R8: reset state
    check("R8", {63'd0, out_valid}, 64'd0);
    check("R8", out_result, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Back-to-back table walk; result for vector j sampled three negedges later (R6, R1)
    last_exp = '0;
    for (int i = 0; i < NV + 3; i++) begin
      if (i >= 3) begin
        {op, a, b} = VEC[i-3];
        last_exp = model(op, a, b);
        check("R6", {63'd0, out_valid}, 64'd1);
        check(req_of(op, a), out_result, last_exp);
      end
      if (i < NV) begin
        {op, a, b} = VEC[i];
        in_valid = 1'b1; in_op = op; in_a = a; in_b = b;
      end else begin
        in_valid = 1'b0;
      end
      @(negedge clk);
    end
    in_valid = 1'b0;

    // R5 explicit value
    check("R5", model(2'b10, 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000),
          64'h8000_0000_8000_0000);

    // R9: idle, result holds
    repeat (2) begin
      check("R9", {63'd0, out_valid}, 64'd0);
      check("R9", out_result, last_exp);
      @(negedge clk);
    end

    // R6: single op, latency exactly three edges
    in_valid = 1'b1; in_op = 2'b01; in_a = 64'h0003_0003_0003_0003; in_b = 64'hFFFF_0002_0001_0000;
    @(negedge clk);
    in_valid = 1'b0; in_a = '0; in_b = '0;
    check("R6", {63'd0, out_valid}, 64'd0);
    @(negedge clk);
    check("R6", {63'd0, out_valid}, 64'd0);
    @(negedge clk);
    check("R6", {63'd0, out_valid}, 64'd1);
    check("R3", out_result, 64'hFFFD_0006_0003_0000);
    @(negedge clk);
    check("R6", {63'd0, out_valid}, 64'd0);

    // R8: reset with the pipeline full
    for (int i = 0; i < 3; i++) begin
      in_valid = 1'b1; in_op = 2'b00; in_a = 64'h7FFF_7FFF_7FFF_7FFF; in_b = 64'h7FFF_7FFF_7FFF_7FFF;
      @(negedge clk);
    end
    in_valid = 1'b0;
    check("R6", {63'd0, out_valid}, 64'd1);
    check("R2", out_result, 64'h3FFF_3FFF_3FFF_3FFF);
    #1 rst_n = 1'b0;
    #0.5;
    check("R8", {63'd0, out_valid}, 64'd0);
    check("R8", out_result, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R8", {63'd0, out_valid}, 64'd0);
    end

    done = 1;
    summary();
  end

endmodule